// File: doc/BRIEF.md
# Bit-Masked GPIO Register Bank

This block is the register file behind an 8-line general-purpose I/O port. It sits on a simple synchronous byte-wide register bus with an address, a write enable, write data and a registered read-data output. It holds the output latch, the per-line direction bits and four interrupt configuration bytes. It drives the pin outputs and output enables, and it exports the interrupt configuration to a separate event detector.

Accesses to the data window use the address itself as a per-line mask. Address bits [9:2] select which lines a read or write touches, so software can set, clear or sample any subset of lines in one bus cycle. It never needs a read-modify-write sequence.

A data write never changes the latch bit of a line that is currently an input. Software therefore writes the value again after it turns a line into an output. Edge and level detection are not part of this block. It reports the raw event vector it receives, reports that vector gated by the enable byte, and issues a one-cycle clear pulse when software writes the clear offset.

Top module: `gpio_bank`

## Requirements
- R1: While reset is asserted, and right after it is released, direction, output latch, pinOut, pinOe, all four configuration outputs, intClr and rdData are zero.
- R2: A write to any address below 0x400 updates latch bit n only when address bit n+2 is 1 and direction bit n is 1. All other latch bits hold, and with no data write the latch holds.
- R3: A data write to a line whose direction bit is 0 leaves that latch bit unchanged. The value takes effect only when it is written again after the direction bit is set to 1.
- R4: A read below 0x400 returns zero in every bit whose address bit n+2 is 0. In the other bits it returns the latch for output lines and the pin input for input lines. The pin input reaches rdData three clock edges after it changes: two synchronizer stages, then the read register.
- R5: The direction byte sits at 0x400 and can be read and written. Bit value 1 makes the line an output, and pinOe equals the direction byte.
- R6: The configuration bytes can be read and written, and each drives its own output. Sense is at 0x404 (cfgSense), both-edges at 0x408 (cfgBoth), polarity at 0x40C (cfgPol) and enable at 0x410 (cfgEn).
- R7: A read of 0x414 returns rawStat, and a read of 0x418 returns rawStat AND cfgEn. Writes to either offset change nothing.
- R8: A write to 0x41C makes intClr equal to wrData for exactly the next clock cycle. At all other times intClr is zero, and a read of 0x41C returns zero.
- R9: At unmapped offsets (0x420 and above, or any non-listed offset at or above 0x400), reads return zero and writes change no register.
- R10: pinOut always equals the output latch.
- R11: rdData is registered. It shows the state before any write that happens in the same cycle as the read, and it shows the new value one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 12 | Byte address of the access |
| wrEn | input | 1 | Write strobe for the current cycle |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data for the previous cycle's address |
| pinIn | input | 8 | Asynchronous pin levels |
| pinOut | output | 8 | Output latch to the pads |
| pinOe | output | 8 | Per-line output enable |
| rawStat | input | 8 | Event vector from the external detector |
| cfgSense | output | 8 | Level (1) or edge (0) sense per line |
| cfgBoth | output | 8 | Both-edges select per line |
| cfgPol | output | 8 | Event polarity per line |
| cfgEn | output | 8 | Interrupt enable per line |
| intClr | output | 8 | One-cycle clear pulse per line |

## Verification
Every access reads and may also write, so the clash that matters is a read and a write to the same register in one cycle. The table vectors do this on purpose: each write vector also judges rdData, which must show the value from before the write, and the read that follows must show the updated value. A second clash is a masked data write that covers both output and input lines in one cycle. The bench judges it at pinOut: only the bits that are both masked and output lines may move.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Register offsets; the data window is every address below OFS_DIR
  localparam int unsigned OFS_DIR    = 32'h400;
  localparam int unsigned OFS_SENSE  = 32'h404;
  localparam int unsigned OFS_BOTH   = 32'h408;
  localparam int unsigned OFS_POL    = 32'h40C;
  localparam int unsigned OFS_EN     = 32'h410;
  localparam int unsigned OFS_RAW    = 32'h414;
  localparam int unsigned OFS_MASKED = 32'h418;
  localparam int unsigned OFS_CLR    = 32'h41C;

  typedef enum logic [3:0] {
    RD_NONE,
    RD_DATA,
    RD_DIR,
    RD_SENSE,
    RD_BOTH,
    RD_POL,
    RD_EN,
    RD_RAW,
    RD_MASKED
  } rdSel_e;

  typedef struct packed {
    logic   dataWr;
    logic   dirWr;
    logic   senseWr;
    logic   bothWr;
    logic   polWr;
    logic   enWr;
    logic   clrWr;
    rdSel_e rdSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LINES  = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  output ctrlStrobes_t      strb,
  output logic [LINES-1:0]  accMask
);

  localparam logic [ADDR_W-1:0] DATA_LIMIT = ADDR_W'(OFS_DIR);

  logic inData;

  assign inData  = (addr < DATA_LIMIT);
  assign accMask = addr[LINES+1:2];

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_NONE;
    if (inData) begin
      strb.dataWr = wrEn;
      strb.rdSel  = RD_DATA;
    end else begin
      case (addr)
        ADDR_W'(OFS_DIR):    begin strb.dirWr   = wrEn; strb.rdSel = RD_DIR;   end
        ADDR_W'(OFS_SENSE):  begin strb.senseWr = wrEn; strb.rdSel = RD_SENSE; end
        ADDR_W'(OFS_BOTH):   begin strb.bothWr  = wrEn; strb.rdSel = RD_BOTH;  end
        ADDR_W'(OFS_POL):    begin strb.polWr   = wrEn; strb.rdSel = RD_POL;   end
        ADDR_W'(OFS_EN):     begin strb.enWr    = wrEn; strb.rdSel = RD_EN;    end
        ADDR_W'(OFS_RAW):    strb.rdSel = RD_RAW;
        ADDR_W'(OFS_MASKED): strb.rdSel = RD_MASKED;
        ADDR_W'(OFS_CLR):    strb.clrWr = wrEn;
        default:             strb.rdSel = RD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/gpio_bank_dpath.sv
module gpio_bank_dpath
  import gpio_bank_pkg::*;
#(
  parameter int LINES       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strb,
  input  logic [LINES-1:0] accMask,
  input  logic [LINES-1:0] wrData,
  input  logic [LINES-1:0] pinIn,
  input  logic [LINES-1:0] rawStat,
  output logic [LINES-1:0] rdData,
  output logic [LINES-1:0] pinOut,
  output logic [LINES-1:0] pinOe,
  output logic [LINES-1:0] cfgSense,
  output logic [LINES-1:0] cfgBoth,
  output logic [LINES-1:0] cfgPol,
  output logic [LINES-1:0] cfgEn,
  output logic [LINES-1:0] intClr
);

  logic [LINES-1:0] outLatch, dirQ, senseQ, bothQ, polQ, enQ, clrQ;
  logic [LINES-1:0] syncQ [SYNC_STAGES];
  logic [LINES-1:0] pinSync, lineVal, rdNext, latchWrMask;

  // Pin input synchronizer chain
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       syncQ[s] <= '0;
      else if (s == 0) syncQ[s] <= pinIn;
      else             syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
    end
  end
  assign pinSync = syncQ[SYNC_STAGES-1];

  // Only masked lines that are outputs accept data writes
  assign latchWrMask = accMask & dirQ;
  assign lineVal     = (outLatch & dirQ) | (pinSync & ~dirQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outLatch <= '0;
      dirQ     <= '0;
      senseQ   <= '0;
      bothQ    <= '0;
      polQ     <= '0;
      enQ      <= '0;
      clrQ     <= '0;
    end else begin
      if (strb.dataWr)  outLatch <= (outLatch & ~latchWrMask) | (wrData & latchWrMask);
      if (strb.dirWr)   dirQ     <= wrData;
      if (strb.senseWr) senseQ   <= wrData;
      if (strb.bothWr)  bothQ    <= wrData;
      if (strb.polWr)   polQ     <= wrData;
      if (strb.enWr)    enQ      <= wrData;
      clrQ <= strb.clrWr ? wrData : '0;
    end
  end

  always_comb begin
    case (strb.rdSel)
      RD_DATA:   rdNext = lineVal & accMask;
      RD_DIR:    rdNext = dirQ;
      RD_SENSE:  rdNext = senseQ;
      RD_BOTH:   rdNext = bothQ;
      RD_POL:    rdNext = polQ;
      RD_EN:     rdNext = enQ;
      RD_RAW:    rdNext = rawStat;
      RD_MASKED: rdNext = rawStat & enQ;
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end

  assign pinOut   = outLatch;
  assign pinOe    = dirQ;
  assign cfgSense = senseQ;
  assign cfgBoth  = bothQ;
  assign cfgPol   = polQ;
  assign cfgEn    = enQ;
  assign intClr   = clrQ;

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int LINES       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [LINES-1:0]  wrData,
  output logic [LINES-1:0]  rdData,
  input  logic [LINES-1:0]  pinIn,
  output logic [LINES-1:0]  pinOut,
  output logic [LINES-1:0]  pinOe,
  input  logic [LINES-1:0]  rawStat,
  output logic [LINES-1:0]  cfgSense,
  output logic [LINES-1:0]  cfgBoth,
  output logic [LINES-1:0]  cfgPol,
  output logic [LINES-1:0]  cfgEn,
  output logic [LINES-1:0]  intClr
);

  ctrlStrobes_t     strb;
  logic [LINES-1:0] accMask;

  gpio_bank_ctrl #(.ADDR_W(ADDR_W), .LINES(LINES)) uCtrl (
    .addr    (addr),
    .wrEn    (wrEn),
    .strb    (strb),
    .accMask (accMask)
  );

  gpio_bank_dpath #(.LINES(LINES), .SYNC_STAGES(SYNC_STAGES)) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .accMask  (accMask),
    .wrData   (wrData),
    .pinIn    (pinIn),
    .rawStat  (rawStat),
    .rdData   (rdData),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .cfgSense (cfgSense),
    .cfgBoth  (cfgBoth),
    .cfgPol   (cfgPol),
    .cfgEn    (cfgEn),
    .intClr   (intClr)
  );

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LINES  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic [LINES-1:0]  rdData,
  input logic [LINES-1:0]  pinOut,
  input logic [LINES-1:0]  pinOe,
  input logic [LINES-1:0]  cfgEn,
  input logic [LINES-1:0]  intClr
);

  logic             isData;
  logic [LINES-1:0] mask;

  assign isData = (addr < ADDR_W'(OFS_DIR));
  assign mask   = addr[LINES+1:2];

  AST_UNMASKED_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && isData) |=> ((pinOut ^ $past(pinOut)) & ~$past(mask)) == '0); // R2

  AST_LATCH_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && isData) |=> $stable(pinOut)); // R2

  AST_INPUT_LINE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && isData) |=> ((pinOut ^ $past(pinOut)) & ~$past(pinOe)) == '0); // R3

  AST_RD_UNMASKED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    isData |=> (rdData & ~$past(mask)) == '0); // R4

  AST_OE_ONLY_ON_DIR_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == ADDR_W'(OFS_DIR)) |=> $stable(pinOe)); // R5

  AST_MASKED_SUBSET: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_W'(OFS_MASKED)) |=> (rdData & ~$past(cfgEn)) == '0); // R7

  AST_CLR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == ADDR_W'(OFS_CLR)) |=> intClr == '0); // R8

  AST_CLR_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_W'(OFS_CLR)) |=> rdData == '0); // R8

endmodule

bind gpio_bank gpio_bank_chk #(.ADDR_W(ADDR_W), .LINES(LINES)) uChk (
  .clk    (clk),
  .rstN   (rstN),
  .addr   (addr),
  .wrEn   (wrEn),
  .rdData (rdData),
  .pinOut (pinOut),
  .pinOe  (pinOe),
  .cfgEn  (cfgEn),
  .intClr (intClr)
);

// File: tb/tb_gpio_bank.sv
`timescale 1ns/1ps
module tb_gpio_bank;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] addr = '0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData, pinOut, pinOe, cfgSense, cfgBoth, cfgPol, cfgEn, intClr;
  logic [7:0]  pinIn = '0;
  logic [7:0]  rawStat = '0;

  int nVec = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  gpio_bank dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .rawStat(rawStat), .cfgSense(cfgSense), .cfgBoth(cfgBoth),
    .cfgPol(cfgPol), .cfgEn(cfgEn), .intClr(intClr)
  );

  // {wr, addr, wrData, expRd, expPinOut, expPinOe}; pinIn=0x3C, rawStat=0x96
  localparam int NV = 26;
  localparam logic [44:0] TABLE [NV] = '{
    {1'b1, 12'h400, 8'hF0, 8'h00, 8'h00, 8'hF0},
    {1'b0, 12'h400, 8'h00, 8'hF0, 8'h00, 8'hF0},
    {1'b1, 12'h3FC, 8'hAA, 8'h0C, 8'hA0, 8'hF0},
    {1'b0, 12'h3FC, 8'h00, 8'hAC, 8'hA0, 8'hF0},
    {1'b1, 12'h200, 8'h00, 8'h80, 8'h20, 8'hF0},
    {1'b1, 12'h044, 8'hFF, 8'h00, 8'h30, 8'hF0},
    {1'b0, 12'h3FC, 8'h00, 8'h3C, 8'h30, 8'hF0},
    {1'b0, 12'h03C, 8'h00, 8'h0C, 8'h30, 8'hF0},
    {1'b1, 12'h404, 8'h5A, 8'h00, 8'h30, 8'hF0},
    {1'b0, 12'h404, 8'h00, 8'h5A, 8'h30, 8'hF0},
    {1'b1, 12'h408, 8'h33, 8'h00, 8'h30, 8'hF0},
    {1'b0, 12'h408, 8'h00, 8'h33, 8'h30, 8'hF0},
    {1'b1, 12'h40C, 8'hC3, 8'h00, 8'h30, 8'hF0},
    {1'b0, 12'h40C, 8'h00, 8'hC3, 8'h30, 8'hF0},
    {1'b1, 12'h410, 8'h0F, 8'h00, 8'h30, 8'hF0},
    {1'b0, 12'h410, 8'h00, 8'h0F, 8'h30, 8'hF0},
    {1'b0, 12'h414, 8'h00, 8'h96, 8'h30, 8'hF0},
    {1'b0, 12'h418, 8'h00, 8'h06, 8'h30, 8'hF0},
    {1'b1, 12'h414, 8'hFF, 8'h96, 8'h30, 8'hF0},
    {1'b0, 12'h414, 8'h00, 8'h96, 8'h30, 8'hF0},
    {1'b1, 12'h41C, 8'hFF, 8'h00, 8'h30, 8'hF0},
    {1'b0, 12'h41C, 8'h00, 8'h00, 8'h30, 8'hF0},
    {1'b1, 12'h420, 8'hFF, 8'h00, 8'h30, 8'hF0},
    {1'b0, 12'h7FC, 8'h00, 8'h00, 8'h30, 8'hF0},
    {1'b1, 12'h400, 8'h0F, 8'hF0, 8'h30, 8'h0F},
    {1'b0, 12'h3FC, 8'h00, 8'h30, 8'h30, 8'h0F}
  };

  function automatic string tagOf(input logic [11:0] a);
    if (a < 12'h400)       return "R2 R4 R11";
    else if (a == 12'h400) return "R5 R11";
    else if (a <= 12'h410) return "R6 R11";
    else if (a <= 12'h418) return "R7";
    else if (a == 12'h41C) return "R8";
    else                   return "R9";
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [11:0] a, input logic [7:0] d);
    wrEn = w; addr = a; wrData = d;
    @(posedge clk);
    #1;
    wrEn = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset rdData", rdData, 8'h00);
    check("R1 reset pinOe", pinOe, 8'h00);
    rstN = 1'b1;
    check("R1 reset pinOut", pinOut, 8'h00);
    check("R1 reset cfg", cfgSense | cfgBoth | cfgPol | cfgEn | intClr, 8'h00);
    pinIn = 8'h3C;
    rawStat = 8'h96;
    repeat (4) step(1'b0, 12'h000, 8'h00);

    for (int i = 0; i < NV; i++) begin
      step(TABLE[i][44], TABLE[i][43:32], TABLE[i][31:24]);
      check($sformatf("%s vec %0d rdData", tagOf(TABLE[i][43:32]), i), rdData, TABLE[i][23:16]);
      check($sformatf("R10 vec %0d pinOut", i), pinOut, TABLE[i][15:8]);
      check($sformatf("R5 vec %0d pinOe", i), pinOe, TABLE[i][7:0]);
    end

    check("R6 cfgSense", cfgSense, 8'h5A);
    check("R6 cfgBoth", cfgBoth, 8'h33);
    check("R6 cfgPol", cfgPol, 8'hC3);
    check("R6 cfgEn", cfgEn, 8'h0F);

    // R8 clear pulse lasts one cycle
    step(1'b1, 12'h41C, 8'h81);
    check("R8 intClr pulse", intClr, 8'h81);
    step(1'b0, 12'h000, 8'h00);
    check("R8 intClr drops", intClr, 8'h00);

    // R3 write to input line ignored, takes effect after rewrite
    step(1'b1, 12'h100, 8'hFF);
    check("R3 input line write ignored", pinOut, 8'h30);
    step(1'b1, 12'h400, 8'h4F);
    check("R3 no effect on direction change", pinOut, 8'h30);
    step(1'b1, 12'h100, 8'hFF);
    check("R3 rewrite as output", pinOut, 8'h70);

    // R4 pin synchronizer latency, mask 0xB0 (lines 7,5,4 inputs)
    pinIn = 8'hA0;
    step(1'b0, 12'h2C0, 8'h00);
    check("R4 pin not yet visible", rdData, 8'h30);
    step(1'b0, 12'h2C0, 8'h00);
    step(1'b0, 12'h2C0, 8'h00);
    check("R4 pin after three edges", rdData, 8'hA0);

    // R9 unmapped write changed nothing
    step(1'b1, 12'h424, 8'hFF);
    step(1'b0, 12'h400, 8'h00);
    check("R9 direction intact", rdData, 8'h4F);

    finished = 1'b1;
    summary();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

endmodule